// File: doc/BRIEF.md
# Shared-Counter Wilkinson Conversion Back End

This block is the digital half of a ramp-compare converter that serves many channels at once. A single Gray-coded counter, `BITS` wide, steps once per clock while an external common ramp rises. Each channel watches its own comparator. The comparator line first passes through a two-flop synchronizer and an edge detector. On the first rising edge after a start, the channel stores the counter's current Gray value.

When the counter has stepped through all 2^BITS codes and wrapped, the block raises a done flag. It then streams the stored values out as binary, one channel per clock in ascending channel order. Each value travels with the gain-select bit that was set for that channel when the conversion started.

A channel that sees no rising edge during the ramp reports the full-scale code. This includes a comparator that was already high before the start. The ramp generator and the comparators themselves live outside this block.

Top module: `wadc_conv_top`

## Requirements
- R1: After reset, `conv_done` and `res_valid` are low.
- R2: A `start` pulse seen at clock edge 0 while idle begins a conversion. `conv_done` is still low after edge 2^BITS-1 and is high after edge 2^BITS.
- R3: Suppose a comparator rises between clock edges k and k+1 after the start edge, and k+2 <= 2^BITS-1. That channel's result is the binary code k+2, the offset coming from the two-flop synchronizer.
- R4: After a channel has captured a value, further comparator edges in the same conversion leave its result unchanged.
- R5: A channel with no rising comparator edge during the ramp reports 2^BITS-1. This covers a comparator held low throughout and one that was already high before the start.
- R6: Results appear on `res_valid` for NCH consecutive cycles, beginning one cycle after `conv_done` rises, with `res_chan` counting 0, 1, ..., NCH-1.
- R7: `res_gain` of each result equals that channel's `gain_sel` bit sampled at the start edge; later changes to `gain_sel` have no effect.
- R8: `start` is ignored while a conversion or its readout is in progress, so results and done timing are those of the undisturbed conversion.
- R9: `conv_done` stays high after readout until the next accepted start, and is low after that start edge.
- R10: The shared count moves by exactly one bit per clock during the ramp. Every reachable capture point from 2 to 2^BITS-1 reads back as the matching binary code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and logic clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a conversion when idle |
| cmp_in | input | NCH | Asynchronous comparator outputs, one per channel |
| gain_sel | input | NCH | Gain selection per channel, sampled at start |
| conv_done | output | 1 | High from counter wrap until the next accepted start |
| res_valid | output | 1 | A result is on the result bus this cycle |
| res_chan | output | CW | Channel index of the current result |
| res_code | output | BITS | Binary conversion result |
| res_gain | output | 1 | Gain bit belonging to the current result |

## Verification
The hardest case to reach from the ports is a capture on the very last Gray code. It only happens when a comparator rises exactly two cycles before the counter wraps, so the synchronizer delay and the end of the ramp coincide. The bench runs a small configuration (6-bit count, four channels) and steps each channel's rise point across every cycle of the ramp over sixteen conversions. This makes every capture point occur, including the final one and points beyond the wrap. Separate conversions bounce comparators after capture, hold one high across the start, and pulse `start` mid-ramp and mid-readout.

// File: rtl/wadc_pkg.sv
// Shared types and code conversions for the Wilkinson back end.
// Assumes codes of at most 32 bits.
package wadc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_RAMP  = 2'd1,
        PH_DRAIN = 2'd2
    } wadc_phase_e;

    // Binary to reflected Gray code.
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary (prefix XOR from the top bit).
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/wadc_gray_ctr.sv
// Shared Gray-coded ramp counter.
// Clears to zero on `clear`, advances one code per clock while `run`,
// wraps after the all-ones binary position. `at_last` flags the final code.
// Assumes clear and run are never high together.
module wadc_gray_ctr #(
    parameter int BITS = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            run,
    output logic [BITS-1:0] gray_q,
    output logic            at_last
);
    import wadc_pkg::*;

    localparam logic [BITS-1:0] LAST_GRAY = {1'b1, {(BITS-1){1'b0}}};

    logic [BITS-1:0] bin_now;
    logic [BITS-1:0] bin_nxt;
    logic [BITS-1:0] gray_nxt;

    // Next Gray code: decode, increment, re-encode.
    always_comb begin
        bin_now  = BITS'(from_gray(32'(gray_q)));
        bin_nxt  = bin_now + 1'b1;
        gray_nxt = BITS'(to_gray(32'(bin_nxt)));
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            gray_q <= '0;
        end else if (run) begin
            gray_q <= gray_nxt;
        end
    end

    assign at_last = (gray_q == LAST_GRAY);

    p_gray_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear) |=> ($countones(gray_q ^ $past(gray_q)) == 1))
        else $error("gray counter moved by other than one bit");

endmodule

// File: rtl/wadc_chan.sv
// One converter channel.
// Synchronizes the comparator line, detects its rising edge, and stores
// the shared Gray count on the first such edge while `open`.
// `arm` (start) preloads the full-scale code and samples the gain bit.
// Assumes arm and open are not high together.
module wadc_chan #(
    parameter int BITS = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic            open,
    input  logic            cmp_in,
    input  logic            gain_in,
    input  logic [BITS-1:0] count_gray,
    output logic [BITS-1:0] code_gray,
    output logic            gain_q
);
    localparam logic [BITS-1:0] FULL_GRAY = {1'b1, {(BITS-1){1'b0}}};

    logic sync_a, sync_b, sync_prev;
    logic rise;
    logic hit_q;

    // Two-flop synchronizer plus a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a    <= 1'b0;
            sync_b    <= 1'b0;
            sync_prev <= 1'b0;
        end else begin
            sync_a    <= cmp_in;
            sync_b    <= sync_a;
            sync_prev <= sync_b;
        end
    end

    assign rise = sync_b && !sync_prev;

    // Capture the count on the first rising edge of the ramp.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_gray <= FULL_GRAY;
            gain_q    <= 1'b0;
            hit_q     <= 1'b0;
        end else if (arm) begin
            code_gray <= FULL_GRAY;
            gain_q    <= gain_in;
            hit_q     <= 1'b0;
        end else if (open && rise && !hit_q) begin
            code_gray <= count_gray;
            hit_q     <= 1'b1;
        end
    end

    p_capture_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (open && rise && !hit_q && !arm) |=> (code_gray == $past(count_gray)))
        else $error("capture did not take the shared count");

    p_hold_after_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_q && !arm) |=> $stable(code_gray))
        else $error("captured code changed after first hit");

endmodule

// File: rtl/wadc_readout.sv
// Result streamer.
// On `go`, walks the channels from 0 to NCH-1, one per clock, presenting
// each stored Gray code converted to binary together with its gain bit.
// Assumes go is not raised while busy.
module wadc_readout #(
    parameter int BITS = 12,
    parameter int NCH  = 36,
    localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      go,
    input  logic [NCH-1:0][BITS-1:0]  codes,
    input  logic [NCH-1:0]            gains,
    output logic                      busy,
    output logic                      valid,
    output logic [CW-1:0]             chan,
    output logic [BITS-1:0]           code,
    output logic                      gain
);
    import wadc_pkg::*;

    localparam logic [CW-1:0] LAST = CW'(NCH - 1);

    logic [CW-1:0] idx;

    // Walk the channel index and register one result per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            idx   <= '0;
            valid <= 1'b0;
            chan  <= '0;
            code  <= '0;
            gain  <= 1'b0;
        end else begin
            valid <= busy;
            if (go) begin
                busy <= 1'b1;
                idx  <= '0;
            end else if (busy) begin
                chan <= idx;
                code <= BITS'(from_gray(32'(codes[idx])));
                gain <= gains[idx];
                if (idx == LAST) begin
                    busy <= 1'b0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    p_chan_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && chan != LAST) |=> (valid && chan == $past(chan) + 1'b1))
        else $error("readout skipped or repeated a channel");

endmodule

// File: rtl/wadc_conv_top.sv
// Multi-channel Wilkinson conversion back end.
// Sequences idle -> ramp -> drain: a start while idle clears the shared
// Gray counter and arms all channels; the ramp lasts 2^BITS clocks; on the
// wrap the done flag rises and the results stream out in channel order.
// Assumes the external ramp is restarted in step with `start`.
module wadc_conv_top #(
    parameter int BITS = 12,
    parameter int NCH  = 36,
    localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NCH-1:0]  cmp_in,
    input  logic [NCH-1:0]  gain_sel,
    output logic            conv_done,
    output logic            res_valid,
    output logic [CW-1:0]   res_chan,
    output logic [BITS-1:0] res_code,
    output logic            res_gain
);
    import wadc_pkg::*;

    wadc_phase_e               phase_q;
    logic                      start_ok;
    logic                      running;
    logic                      at_last;
    logic                      wrap;
    logic                      rd_busy;
    logic [BITS-1:0]           count_gray;
    logic [NCH-1:0][BITS-1:0]  codes;
    logic [NCH-1:0]            gains;

    assign start_ok = start && (phase_q == PH_IDLE);
    assign running  = (phase_q == PH_RAMP);
    assign wrap     = running && at_last;

    // Phase sequencing and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            conv_done <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: if (start) begin
                    phase_q   <= PH_RAMP;
                    conv_done <= 1'b0;
                end
                PH_RAMP: if (at_last) begin
                    phase_q   <= PH_DRAIN;
                    conv_done <= 1'b1;
                end
                PH_DRAIN: if (!rd_busy) begin
                    phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    wadc_gray_ctr #(.BITS(BITS)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start_ok),
        .run     (running),
        .gray_q  (count_gray),
        .at_last (at_last)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        wadc_chan #(.BITS(BITS)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .arm        (start_ok),
            .open       (running),
            .cmp_in     (cmp_in[c]),
            .gain_in    (gain_sel[c]),
            .count_gray (count_gray),
            .code_gray  (codes[c]),
            .gain_q     (gains[c])
        );
    end

    wadc_readout #(.BITS(BITS), .NCH(NCH)) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (wrap),
        .codes (codes),
        .gains (gains),
        .busy  (rd_busy),
        .valid (res_valid),
        .chan  (res_chan),
        .code  (res_code),
        .gain  (res_gain)
    );

    p_done_on_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_done) |-> $past(wrap))
        else $error("done rose without a counter wrap");

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && running && !at_last) |=> (phase_q == PH_RAMP))
        else $error("start disturbed a running ramp");

    p_valid_in_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (phase_q == PH_DRAIN))
        else $error("result presented outside readout");

    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !start_ok) |=> conv_done)
        else $error("done dropped without a start");

endmodule

// File: tb/tb_wadc_conv_top.sv
`timescale 1ns/1ps
module tb_wadc_conv_top;
    localparam int BITS = 6;
    localparam int NCH  = 4;
    localparam int CW   = 2;
    localparam int SPAN = 1 << BITS;
    localparam int MAXC = SPAN - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [NCH-1:0]  cmp_in = '0;
    logic [NCH-1:0]  gain_sel = '0;
    logic            conv_done;
    logic            res_valid;
    logic [CW-1:0]   res_chan;
    logic [BITS-1:0] res_code;
    logic            res_gain;

    int n_cmp = 0;
    int n_bad = 0;
    int j_at [NCH];
    int mode [NCH];      // 0 rise and stay, 1 bounce, 2 never, 3 high before start
    logic [NCH-1:0] g_set;
    bit  poke;
    string code_tag;

    wadc_conv_top #(.BITS(BITS), .NCH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_in(cmp_in),
        .gain_sel(gain_sel), .conv_done(conv_done), .res_valid(res_valid),
        .res_chan(res_chan), .res_code(res_code), .res_gain(res_gain)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input int c);
        if (mode[c] >= 2) return MAXC;
        return (j_at[c] + 2 > MAXC) ? MAXC : j_at[c] + 2;
    endfunction

    function automatic string tag_of(input int c);
        if (mode[c] == 1) return "R4";
        if (mode[c] >= 2) return "R5";
        return code_tag;
    endfunction

    task automatic run_conv();
        int got = 0;
        @(negedge clk);
        gain_sel = g_set;
        for (int c = 0; c < NCH; c++) cmp_in[c] = (mode[c] == 3);
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk);                 // just after start edge (edge 0)
        start = 1'b0;
        gain_sel = ~g_set;              // R7: must not matter now
        for (int k = 0; k <= SPAN + NCH + 3; k++) begin
            if (k == 0) chk(conv_done == 1'b0, "R9", int'(conv_done), 0);
            for (int c = 0; c < NCH; c++) begin
                case (mode[c])
                    0: cmp_in[c] = (k >= j_at[c]);
                    1: cmp_in[c] = (k >= j_at[c] && k < j_at[c] + 3) || (k >= j_at[c] + 6);
                    2: cmp_in[c] = 1'b0;
                    default: cmp_in[c] = 1'b1;
                endcase
            end
            start = poke && (k == 10 || k == SPAN + 2);
            if (k == SPAN - 1) chk(conv_done == 1'b0, "R2", int'(conv_done), 0);
            if (k == SPAN) begin
                chk(conv_done == 1'b1, poke ? "R8" : "R2", int'(conv_done), 1);
                chk(res_valid == 1'b0, "R6", int'(res_valid), 0);
            end
            if (res_valid) begin
                chk(k == SPAN + 1 + got, "R6", k, SPAN + 1 + got);
                chk(int'(res_chan) == got, "R6", int'(res_chan), got);
                chk(int'(res_code) == exp_code(int'(res_chan)), poke ? "R8" : tag_of(int'(res_chan)),
                    int'(res_code), exp_code(int'(res_chan)));
                chk(res_gain == g_set[res_chan], "R7", int'(res_gain), int'(g_set[res_chan]));
                got++;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(got == NCH, "R6", got, NCH);
        chk(conv_done == 1'b1, "R9", int'(conv_done), 1);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        poke = 0;
        code_tag = "R3";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(conv_done == 1'b0, "R1", int'(conv_done), 0);
        chk(res_valid == 1'b0, "R1", int'(res_valid), 0);

        // R10: sweep every rise point across the whole ramp
        code_tag = "R10";
        for (int s = 0; s < SPAN / NCH; s++) begin
            for (int c = 0; c < NCH; c++) begin
                j_at[c] = s * NCH + c;
                mode[c] = 0;
            end
            g_set = NCH'(s);
            run_conv();
        end

        // R3: selected rise points incl. the last reachable code
        code_tag = "R3";
        j_at = '{0, 5, 30, MAXC - 2};
        mode = '{0, 0, 0, 0};
        g_set = 4'b1010;
        run_conv();

        // R4: bouncing comparators
        j_at = '{3, 20, 40, MAXC - 4};
        mode = '{1, 1, 1, 1};
        g_set = 4'b0101;
        run_conv();

        // R5: no edge, or high from before start
        j_at = '{0, 0, 0, 0};
        mode = '{2, 3, 2, 3};
        g_set = 4'b1111;
        run_conv();

        // R8: start pulses during ramp and readout
        poke = 1;
        j_at = '{7, 12, 0, 0};
        mode = '{0, 1, 2, 3};
        g_set = 4'b0110;
        run_conv();
        poke = 0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule